// File: doc/BRIEF.md
# Table-guided circular buffer DMA

This block is a single DMA channel that moves samples between a circular delay-line buffer and a contiguous linear buffer, both held in one word-addressed memory. It does not use a fixed stride. It fetches a table of offsets from memory, one entry per tap. Each tap is a block of consecutive samples whose first sample lies at that offset from a FIFO pointer.

In a gather (read) transfer, each tap is taken from the read pointer plus its offset and packed in tap order into the linear buffer. In a scatter (write) transfer, successive blocks of the linear buffer are stored at the write pointer plus each offset. Every sample address is wrapped into the buffer region in hardware.

Software sets the block up through a small word-addressed register port and sets a start bit. The engine then runs every tap on its own over a one-request-at-a-time memory master, advances its FIFO pointer by one block, and raises a single sticky interrupt. Two table base registers and a select bit let software switch tables between transfers.

Top module: `tgcb_dma`

Register map (word index on `cfg_addr`):

| Index | Write | Read |
|---|---|---|
| 0 | bit0 start, bit1 direction (1 = scatter into the circular buffer), bit2 table select (1 = second table), bit3 clear done and overrun | bit0 busy, bit1 done, bit2 overrun, bit3 direction, bit4 table select |
| 1, 2 | buffer base address, buffer length in words | same |
| 3, 4 | read pointer, write pointer | same |
| 5, 6 | first table base, second table base | same |
| 7 | linear buffer address | same |
| 8 | tap count | same (after clamping) |
| 9 | samples per tap | same |

## Requirements
- R1: In a read transfer, sample s of tap t is read from base + ((rp - base + offset[t] + s) mod len) and written to linear + t*blk + s. Taps are handled in order, and each offset is fetched from the active table at table_base + t just before its tap.
- R2: In a write transfer, linear + t*blk + s is read and stored to base + ((wp - base + offset[t] + s) mod len).
- R3: Wraparound applies to every sample of a tap, so a tap that starts near the end of the region continues at the base address.
- R4: Control bit 2, latched with start, selects the table at register 6 when 1 and the table at register 5 when 0.
- R5: At the end of a transfer the pointer used (rp for read, wp for write) becomes base + ((ptr - base + blk) mod len). Neither pointer changes while a transfer runs.
- R6: A write transfer with fill + blk >= len, where fill = (wp - rp) mod len, is refused. The block makes no memory access, sets overrun (status bit 2) and done, and leaves wp unchanged. fill + blk = len - 1 is accepted.
- R7: The interrupt rises only after the last memory access of a transfer, rises once per transfer, stays high until control bit 3 is written, and equals the status done bit.
- R8: While busy, a start bit and all configuration writes are ignored. No second transfer runs, and register values read back unchanged.
- R9: A tap count above MAX_TAPS (default 32768) is stored as MAX_TAPS. A tap count of 0 makes no memory access but still advances the pointer and sets done.
- R10: The memory master holds at most one request. Address, direction and write data stay stable from the request until the cycle of its acknowledge.
- R11: After reset, status reads 0, the interrupt is low and no memory request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word index |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data (combinational on cfg_addr) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge, one cycle per request |
| irq | output | 1 | Sticky transfer-complete interrupt |

## Verification
The bench goes after taps that straddle the end of the region, on both gather and scatter, and after pointer advances that wrap. A design that wrapped only the first sample of a tap would touch the word just past the buffer, and a design that did not wrap the pointer would drift out of the region. It probes the space check at exactly full and one below full: an off-by-one there would either scatter over unread samples or refuse a legal transfer. It also pokes start and a pointer write while busy, which a design without gating would turn into a second run or a corrupted pointer, and it uses a stretched acknowledge latency, which exposes any request that changes address before it is acknowledged.

// File: rtl/tgcb_pkg.sv
package tgcb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OFS,
      ST_SRC,
      ST_DST,
      ST_FIN
   } eng_state_t;

   localparam int unsigned REG_CTRL = 0;
   localparam int unsigned REG_BASE = 1;
   localparam int unsigned REG_LEN  = 2;
   localparam int unsigned REG_RPTR = 3;
   localparam int unsigned REG_WPTR = 4;
   localparam int unsigned REG_TBLA = 5;
   localparam int unsigned REG_TBLB = 6;
   localparam int unsigned REG_LIN  = 7;
   localparam int unsigned REG_TAPS = 8;
   localparam int unsigned REG_BLK  = 9;

   localparam int unsigned CTRL_START = 0;
   localparam int unsigned CTRL_DIR   = 1;
   localparam int unsigned CTRL_SEL   = 2;
   localparam int unsigned CTRL_CLR   = 3;
endpackage

// File: rtl/tgcb_wrap.sv
// Circular address: base + ((ptr - base + ofs + idx) mod len), with each term below len.
module tgcb_wrap #(
   parameter int AW   = 16,
   parameter int NSUB = 2
) (
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] len,
   input  logic [AW-1:0] ptr,
   input  logic [AW-1:0] ofs,
   input  logic [AW-1:0] idx,
   output logic [AW-1:0] addr
);
   localparam int SW = AW + 2;

   if (NSUB < 2) begin : g_bad_nsub
      $error("tgcb_wrap: NSUB must be at least 2");
   end

   logic [AW-1:0] rel_ptr;
   logic [SW-1:0] stage [NSUB+1];
   logic [SW-1:0] len_x;
   logic [1:0]    wrap_unused_hi;

   assign rel_ptr  = ptr - base;
   assign len_x    = SW'(len);
   assign stage[0] = SW'(rel_ptr) + SW'(ofs) + SW'(idx);

   for (genvar k = 0; k < NSUB; k++) begin : g_sub
      assign stage[k+1] = (stage[k] >= len_x) ? stage[k] - len_x : stage[k];
   end

   assign wrap_unused_hi = stage[NSUB][SW-1:AW];
   assign addr           = base + stage[NSUB][AW-1:0];
endmodule

// File: rtl/tgcb_engine.sv
module tgcb_engine
   import tgcb_pkg::*;
#(
   parameter int AW    = 16,
   parameter int DW    = 32,
   parameter int TAP_W = 16,
   parameter int NSUB  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             dir_wr,
   input  logic [AW-1:0]    buf_base,
   input  logic [AW-1:0]    buf_len,
   input  logic [AW-1:0]    rd_ptr,
   input  logic [AW-1:0]    wr_ptr,
   input  logic [AW-1:0]    tbl_base,
   input  logic [AW-1:0]    lin_base,
   input  logic [AW-1:0]    blk,
   input  logic [TAP_W-1:0] tap_cnt,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic [DW-1:0]    mem_rdata,
   input  logic             mem_ack,
   output logic             busy,
   output logic             fin,
   output logic             refuse
);
   eng_state_t       state;
   logic [TAP_W-1:0] tap_idx;
   logic [AW-1:0]    samp;
   logic [AW-1:0]    ofs;
   logic [DW-1:0]    data;
   logic [AW-1:0]    lin;
   logic [AW-1:0]    circ;
   logic [AW:0]      fill;
   logic             ovf;
   logic             last_samp;
   logic             last_tap;

   if (DW > AW) begin : g_hi
      logic rdata_unused_hi;
      assign rdata_unused_hi = ^mem_rdata[DW-1:AW];
   end

   tgcb_wrap #(.AW(AW), .NSUB(NSUB)) u_wrap (
      .base (buf_base),
      .len  (buf_len),
      .ptr  (dir_wr ? wr_ptr : rd_ptr),
      .ofs  (ofs),
      .idx  (samp),
      .addr (circ)
   );

   // Occupancy between pointers and the space check for a scatter.
   assign fill = (wr_ptr >= rd_ptr) ? {1'b0, wr_ptr - rd_ptr}
                                    : ({1'b0, wr_ptr} + {1'b0, buf_len} - {1'b0, rd_ptr});
   assign ovf       = ({1'b0, fill} + {2'b0, blk}) >= {2'b0, buf_len};
   assign refuse    = start && (state == ST_IDLE) && dir_wr && ovf;
   assign last_samp = (samp == blk - AW'(1));
   assign last_tap  = (tap_idx == tap_cnt - TAP_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         tap_idx <= '0;
         samp    <= '0;
         ofs     <= '0;
         data    <= '0;
         lin     <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start && !(dir_wr && ovf)) begin
               state   <= (tap_cnt == '0) ? ST_FIN : ST_OFS;
               tap_idx <= '0;
               samp    <= '0;
               lin     <= lin_base;
            end
            ST_OFS: if (mem_ack) begin
               ofs   <= mem_rdata[AW-1:0];
               state <= ST_SRC;
            end
            ST_SRC: if (mem_ack) begin
               data  <= mem_rdata;
               state <= ST_DST;
            end
            ST_DST: if (mem_ack) begin
               lin <= lin + AW'(1);
               if (last_samp) begin
                  samp <= '0;
                  if (last_tap) begin
                     state <= ST_FIN;
                  end else begin
                     tap_idx <= tap_idx + TAP_W'(1);
                     state   <= ST_OFS;
                  end
               end else begin
                  samp  <= samp + AW'(1);
                  state <= ST_SRC;
               end
            end
            ST_FIN: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_addr = '0;
      unique case (state)
         ST_OFS:  mem_addr = tbl_base + AW'(tap_idx);
         ST_SRC:  mem_addr = dir_wr ? lin : circ;
         ST_DST:  mem_addr = dir_wr ? circ : lin;
         default: mem_addr = '0;
      endcase
   end

   assign mem_req   = (state == ST_OFS) || (state == ST_SRC) || (state == ST_DST);
   assign mem_we    = (state == ST_DST);
   assign mem_wdata = data;
   assign busy      = (state != ST_IDLE);
   assign fin       = (state == ST_FIN);
endmodule

// File: rtl/tgcb_regs.sv
module tgcb_regs
   import tgcb_pkg::*;
#(
   parameter int AW       = 16,
   parameter int DW       = 32,
   parameter int MAX_TAPS = 32768,
   parameter int TAP_W    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [3:0]       cfg_addr,
   input  logic [DW-1:0]    cfg_wdata,
   output logic [DW-1:0]    cfg_rdata,
   input  logic             eng_busy,
   input  logic             fin,
   input  logic             refuse,
   input  logic [AW-1:0]    nxt_ptr,
   output logic             start_q,
   output logic             busy,
   output logic             dir_wr,
   output logic             done,
   output logic [AW-1:0]    buf_base,
   output logic [AW-1:0]    buf_len,
   output logic [AW-1:0]    rd_ptr,
   output logic [AW-1:0]    wr_ptr,
   output logic [AW-1:0]    tbl_base,
   output logic [AW-1:0]    lin_base,
   output logic [AW-1:0]    blk,
   output logic [TAP_W-1:0] tap_cnt
);
   logic          tbl_sel;
   logic          overrun;
   logic [AW-1:0] tbl_a;
   logic [AW-1:0] tbl_b;
   logic          wr_ok;
   logic          clr;

   assign busy     = eng_busy | start_q;
   assign wr_ok    = cfg_we && !busy;
   assign clr      = cfg_we && (cfg_addr == 4'(REG_CTRL)) && cfg_wdata[CTRL_CLR];
   assign tbl_base = tbl_sel ? tbl_b : tbl_a;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q  <= 1'b0;
         dir_wr   <= 1'b0;
         tbl_sel  <= 1'b0;
         done     <= 1'b0;
         overrun  <= 1'b0;
         buf_base <= '0;
         buf_len  <= '0;
         rd_ptr   <= '0;
         wr_ptr   <= '0;
         tbl_a    <= '0;
         tbl_b    <= '0;
         lin_base <= '0;
         blk      <= '0;
         tap_cnt  <= '0;
      end else begin
         start_q <= 1'b0;
         if (wr_ok) begin
            unique case (cfg_addr)
               4'(REG_CTRL): begin
                  start_q <= cfg_wdata[CTRL_START];
                  dir_wr  <= cfg_wdata[CTRL_DIR];
                  tbl_sel <= cfg_wdata[CTRL_SEL];
               end
               4'(REG_BASE): buf_base <= cfg_wdata[AW-1:0];
               4'(REG_LEN):  buf_len  <= cfg_wdata[AW-1:0];
               4'(REG_RPTR): rd_ptr   <= cfg_wdata[AW-1:0];
               4'(REG_WPTR): wr_ptr   <= cfg_wdata[AW-1:0];
               4'(REG_TBLA): tbl_a    <= cfg_wdata[AW-1:0];
               4'(REG_TBLB): tbl_b    <= cfg_wdata[AW-1:0];
               4'(REG_LIN):  lin_base <= cfg_wdata[AW-1:0];
               4'(REG_TAPS): tap_cnt  <= (cfg_wdata > DW'(MAX_TAPS)) ? TAP_W'(MAX_TAPS)
                                                                     : cfg_wdata[TAP_W-1:0];
               4'(REG_BLK):  blk      <= cfg_wdata[AW-1:0];
               default: ;
            endcase
         end
         if (fin && dir_wr)  wr_ptr <= nxt_ptr;
         if (fin && !dir_wr) rd_ptr <= nxt_ptr;
         if (fin || refuse) done <= 1'b1;
         else if (clr)      done <= 1'b0;
         if (refuse)        overrun <= 1'b1;
         else if (clr)      overrun <= 1'b0;
      end
   end

   always_comb begin
      unique case (cfg_addr)
         4'(REG_CTRL): cfg_rdata = DW'({tbl_sel, dir_wr, overrun, done, busy});
         4'(REG_BASE): cfg_rdata = DW'(buf_base);
         4'(REG_LEN):  cfg_rdata = DW'(buf_len);
         4'(REG_RPTR): cfg_rdata = DW'(rd_ptr);
         4'(REG_WPTR): cfg_rdata = DW'(wr_ptr);
         4'(REG_TBLA): cfg_rdata = DW'(tbl_a);
         4'(REG_TBLB): cfg_rdata = DW'(tbl_b);
         4'(REG_LIN):  cfg_rdata = DW'(lin_base);
         4'(REG_TAPS): cfg_rdata = DW'(tap_cnt);
         4'(REG_BLK):  cfg_rdata = DW'(blk);
         default:      cfg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/tgcb_dma.sv
module tgcb_dma #(
   parameter int AW       = 16,
   parameter int DW       = 32,
   parameter int MAX_TAPS = 32768,
   parameter int NSUB     = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [3:0]    cfg_addr,
   input  logic [DW-1:0] cfg_wdata,
   output logic [DW-1:0] cfg_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_ack,
   output logic          irq
);
   localparam int TAP_W = $clog2(MAX_TAPS + 1);

   if (DW < AW) begin : g_bad_dw
      $error("tgcb_dma: DW must be at least AW");
   end
   if (TAP_W > AW) begin : g_bad_taps
      $error("tgcb_dma: MAX_TAPS needs more bits than AW");
   end
   if (MAX_TAPS < 1) begin : g_bad_max
      $error("tgcb_dma: MAX_TAPS must be positive");
   end

   logic             start_q;
   logic             busy;
   logic             eng_busy;
   logic             eng_fin;
   logic             eng_refuse;
   logic             dir_wr;
   logic             done;
   logic [AW-1:0]    buf_base;
   logic [AW-1:0]    buf_len;
   logic [AW-1:0]    rd_ptr;
   logic [AW-1:0]    wr_ptr;
   logic [AW-1:0]    tbl_base;
   logic [AW-1:0]    lin_base;
   logic [AW-1:0]    blk;
   logic [TAP_W-1:0] tap_cnt;
   logic [AW-1:0]    nxt_ptr;

   tgcb_regs #(.AW(AW), .DW(DW), .MAX_TAPS(MAX_TAPS), .TAP_W(TAP_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .eng_busy(eng_busy), .fin(eng_fin), .refuse(eng_refuse), .nxt_ptr(nxt_ptr),
      .start_q(start_q), .busy(busy), .dir_wr(dir_wr), .done(done),
      .buf_base(buf_base), .buf_len(buf_len), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
      .tbl_base(tbl_base), .lin_base(lin_base), .blk(blk), .tap_cnt(tap_cnt)
   );

   // Pointer advance by one block at the end of a transfer.
   tgcb_wrap #(.AW(AW), .NSUB(NSUB)) u_adv (
      .base(buf_base), .len(buf_len), .ptr(dir_wr ? wr_ptr : rd_ptr),
      .ofs(blk), .idx('0), .addr(nxt_ptr)
   );

   tgcb_engine #(.AW(AW), .DW(DW), .TAP_W(TAP_W), .NSUB(NSUB)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start_q), .dir_wr(dir_wr),
      .buf_base(buf_base), .buf_len(buf_len), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
      .tbl_base(tbl_base), .lin_base(lin_base), .blk(blk), .tap_cnt(tap_cnt),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .busy(eng_busy), .fin(eng_fin), .refuse(eng_refuse)
   );

   assign irq = done;
endmodule

// File: rtl/tgcb_dma_chk.sv
module tgcb_dma_chk #(
   parameter int AW = 16,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_we,
   input logic [3:0]    cfg_addr,
   input logic          clr_bit,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata,
   input logic          mem_ack,
   input logic          irq,
   input logic          busy,
   input logic          fin,
   input logic          refuse,
   input logic [AW-1:0] rd_ptr,
   input logic [AW-1:0] wr_ptr
);
   logic clr_wr;
   assign clr_wr = cfg_we && (cfg_addr == 4'd0) && clr_bit;

   // R10: request fields frozen until acknowledged
   a_r10_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   // R7: interrupt is sticky until cleared
   a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !clr_wr |=> irq);

   // R7: interrupt rises only at the close of a busy period
   a_r7_irq_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(busy));

   // R6: a refused scatter issues no memory request
   a_r6_refuse_silent: assert property (@(posedge clk) disable iff (!rst_n)
      refuse |=> !mem_req);

   // R5: pointers hold while a transfer runs
   a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !fin |=> $stable(rd_ptr) && $stable(wr_ptr));
endmodule

bind tgcb_dma tgcb_dma_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .clr_bit(cfg_wdata[3]),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
   .mem_ack(mem_ack), .irq(irq), .busy(busy), .fin(eng_fin), .refuse(eng_refuse),
   .rd_ptr(rd_ptr), .wr_ptr(wr_ptr)
);

// File: tb/tgcb_dma_bench.sv
module tgcb_dma_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;
   localparam int BASE = 64, LEN = 16, TBLA = 128, TBLB = 136, LIN = 160;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        cfg_we = 0;
   logic [3:0]  cfg_addr = 0;
   logic [31:0] cfg_wdata = 0;
   logic [31:0] cfg_rdata;
   logic        mem_req, mem_we;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = 0;
   logic        mem_ack = 0;
   logic        irq;

   int checks = 0, fails = 0;
   bit done_flag = 0;
   string cur_req = "R1";

   logic [31:0] mem    [256];
   logic [31:0] shadow [256];
   int          q_addr [$];
   bit          q_we   [$];
   logic [31:0] q_data [$];

   int          lat_seed = 0, lat_cnt = 0;
   bit          waiting = 0;
   logic [15:0] h_addr;
   logic        h_we;
   logic [31:0] h_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   tgcb_dma #(.MAX_TAPS(5)) u_tgcb_dma (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .irq(irq)
   );

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic report();
      if (!done_flag) begin
         done_flag = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   // Behavioural memory slave with a rotating acknowledge latency; it also
   // checks each granted access against the expected access queue.
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack = 0;
      end else if (mem_ack) begin
         mem_ack = 0;
      end else if (mem_req) begin
         if (waiting) begin
            chk("R10 held addr", 32'(mem_addr), 32'(h_addr));
            chk("R10 held we", 32'(mem_we), 32'(h_we));
            if (mem_we) chk("R10 held data", mem_wdata, h_data);
         end
         if (lat_cnt != 0) begin
            lat_cnt--;
            waiting = 1;
            h_addr = mem_addr; h_we = mem_we; h_data = mem_wdata;
         end else begin
            waiting = 0;
            if (q_addr.size() == 0) begin
               chk({cur_req, " unexpected access"}, 32'(mem_addr), 32'hFFFF_FFFF);
            end else begin
               chk({cur_req, " addr"}, 32'(mem_addr), 32'(q_addr[0]));
               chk({cur_req, " dir"}, 32'(mem_we), 32'(q_we[0]));
               if (q_we[0]) chk({cur_req, " data"}, mem_wdata, q_data[0]);
               void'(q_addr.pop_front()); void'(q_we.pop_front()); void'(q_data.pop_front());
            end
            if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
            mem_rdata = mem[mem_addr[7:0]];
            mem_ack = 1;
            lat_seed = (lat_seed + 1) % 3;
            lat_cnt = lat_seed;
         end
      end
      if (rst_n && irq && q_addr.size() != 0) chk("R7 irq before last access", 32'(irq), 32'd0);
   end

   task automatic wr(input int a, input int d);
      @(negedge clk); cfg_we = 1; cfg_addr = a[3:0]; cfg_wdata = d;
      @(negedge clk); cfg_we = 0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk); cfg_addr = a[3:0]; #1 d = cfg_rdata;
   endtask

   // Reference model: expected access sequence and final memory image.
   task automatic plan(input bit wdir, input int taps, input int blk, input int ptr,
                       input int tbl, input int lin);
      for (int i = 0; i < 256; i++) shadow[i] = mem[i];
      for (int t = 0; t < taps; t++) begin
         int ofs;
         ofs = int'(shadow[tbl + t]);
         q_addr.push_back(tbl + t); q_we.push_back(0); q_data.push_back(0);
         for (int s = 0; s < blk; s++) begin
            int circ, la, src, dst;
            logic [31:0] v;
            circ = BASE + ((ptr - BASE + ofs + s) % LEN);
            la   = lin + t * blk + s;
            src  = wdir ? la : circ;
            dst  = wdir ? circ : la;
            v    = shadow[src];
            q_addr.push_back(src); q_we.push_back(0); q_data.push_back(0);
            q_addr.push_back(dst); q_we.push_back(1); q_data.push_back(v);
            shadow[dst] = v;
         end
      end
   endtask

   task automatic wait_irq();
      while (!irq) @(negedge clk);
   endtask

   task automatic check_image(input string r);
      int bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) bad++;
      chk({r, " memory image mismatches"}, 32'(bad), 32'd0);
      chk({r, " pending accesses"}, 32'(q_addr.size()), 32'd0);
   endtask

   task automatic run(input string r, input bit wdir, input bit sel, input int taps,
                      input int blk, input int ptr);
      cur_req = r;
      plan(wdir, taps, blk, ptr, sel ? TBLB : TBLA, LIN);
      wr(9, blk);
      wr(0, 1 | (int'(wdir) << 1) | (int'(sel) << 2));
      wait_irq();
      check_image(r);
   endtask

   function automatic int adv(input int ptr, input int blk);
      return BASE + ((ptr - BASE + blk) % LEN);
   endfunction

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      logic [31:0] d;
      for (int i = 0; i < 256; i++) mem[i] = 32'hA000 + i;
      mem[TBLA] = 0;  mem[TBLA+1] = 3; mem[TBLA+2] = 5;
      mem[TBLB] = 1;  mem[TBLB+1] = 7;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R11 reset state
      rd(0, d); chk("R11 status", d, 32'd0);
      chk("R11 irq", 32'(irq), 32'd0);
      chk("R11 req", 32'(mem_req), 32'd0);

      wr(1, BASE); wr(2, LEN); wr(5, TBLA); wr(6, TBLB); wr(7, LIN);

      // R1 R3: gather, taps at offsets 3 and 5 straddle the region end
      wr(3, BASE + 10); wr(8, 3);
      run("R1", 0, 0, 3, 4, BASE + 10);
      rd(3, d); chk("R5 rp advance", d, 32'(adv(BASE + 10, 4)));
      // R7: sticky across idle cycles, then cleared
      repeat (10) @(negedge clk);
      chk("R7 irq sticky", 32'(irq), 32'd1);
      rd(0, d); chk("R7 done bit", d & 32'h2, 32'h2);
      wr(0, 8);
      chk("R7 irq cleared", 32'(irq), 32'd0);

      // R4: second table, R5 pointer wraps to base+2
      wr(8, 2);
      run("R4", 0, 1, 2, 4, adv(BASE + 10, 4));
      rd(3, d); chk("R5 rp wrap", d, 32'(BASE + 2));
      rd(0, d); chk("R4 select bit", d & 32'h10, 32'h10);
      wr(0, 8);

      // R6: exactly full scatter refused (fill 14 + blk 2 = 16)
      cur_req = "R6";
      wr(4, BASE); wr(9, 2);
      wr(0, 3);
      repeat (8) @(negedge clk);
      chk("R6 irq on refuse", 32'(irq), 32'd1);
      rd(0, d); chk("R6 overrun bit", d & 32'h6, 32'h6);
      rd(4, d); chk("R6 wp unchanged", d, 32'(BASE));
      wr(0, 8);
      rd(0, d); chk("R6 overrun cleared", d & 32'h6, 32'h0);

      // R6 boundary: fill 14 + blk 1 = 15 accepted
      run("R6", 1, 1, 2, 1, BASE);
      rd(4, d); chk("R6 accepted wp", d, 32'(BASE + 1));
      wr(0, 8);

      // R2 R3: scatter with a tap wrapping the end of the region
      mem[TBLA] = 14; mem[TBLA+1] = 0; mem[TBLA+2] = 5;
      wr(3, BASE + 8); wr(4, BASE + 2); wr(8, 3);
      run("R2", 1, 0, 3, 2, BASE + 2);
      rd(4, d); chk("R5 wp advance", d, 32'(BASE + 4));
      wr(0, 8);

      // R9: clamp and zero count
      wr(8, 7);
      rd(8, d); chk("R9 tap clamp readback", d, 32'd5);
      mem[TBLA] = 1; mem[TBLA+1] = 2; mem[TBLA+2] = 3; mem[TBLA+3] = 4; mem[TBLA+4] = 15;
      wr(3, BASE);
      run("R9", 0, 0, 5, 1, BASE);
      rd(3, d); chk("R9 rp after clamp", d, 32'(BASE + 1));
      wr(0, 8);
      wr(8, 0);
      run("R9", 0, 0, 0, 1, BASE + 1);
      rd(3, d); chk("R9 zero count advance", d, 32'(BASE + 2));
      wr(0, 8);

      // R8: start and register writes while busy are ignored
      cur_req = "R8";
      wr(8, 5);
      plan(0, 5, 4, BASE + 2, TBLA, LIN);
      wr(9, 4);
      wr(0, 1);
      wr(0, 3); wr(3, 99); wr(7, 200);
      rd(0, d); chk("R8 busy bit", d & 32'h1, 32'h1);
      wait_irq();
      repeat (50) @(negedge clk);
      check_image("R8");
      rd(3, d); chk("R8 rp", d, 32'(adv(BASE + 2, 4)));
      rd(7, d); chk("R8 linear unchanged", d, 32'(LIN));
      rd(0, d); chk("R8 direction unchanged", d & 32'h8, 32'h0);
      wr(0, 8);

      report();
   end
endmodule